// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Byte Synchronisation

This block sits behind a clock-and-data-recovery front end. It takes one retimed serial bit per bit-clock cycle and rebuilds 10-bit characters. It presents each character on a parallel bus together with a one-cycle byte-clock enable. While alignment is enabled, it watches the stream for the seven-bit prefix `0011111` of a positive-disparity comma. It then moves the character boundary so that the first bit of that comma lands in bit 0 of the parallel word.

A boundary move only ever lengthens the byte period that is running when the comma is seen. The byte period is never shortened. The partial character caught across the old boundary is dropped, and the comma itself is delivered intact with a one-cycle comma flag. A loss-of-signal input forces the parallel word to all ones and suspends comma hunting, so a dead line cannot produce random data or false realignments.

The detector looks seven bits ahead of the word being assembled. For that reason, a character leaves the block a fixed 16 bit clocks after its first bit arrives, whether or not a realignment takes place.

Top module: `comma_deser`

## Requirements
- R1: While `rst_n` is low at a clock edge, `data_out` becomes 0 and `byte_stb` and `comma_flag` become 0.
- R2: After reset, the framing starts at the first bit received. A character whose first bit is sampled at edge k is shown on `data_out` after edge k+16, with `data_out[i]` equal to its i-th received bit. Without realignment, `byte_stb` pulses high for exactly one cycle every 10 bit clocks, and `data_out` holds between pulses.
- R3: With `align_en` high and `los` low, seven consecutive bits arriving as 0,0,1,1,1,1,1 start a new character. That character is delivered with `data_out[6:0] == 7'b1111100`, and `comma_flag` is high in the same cycle as its `byte_stb`.
- R4: With `align_en` low, a comma prefix in the stream changes neither the framing nor the strobe period, and `comma_flag` stays low.
- R5: Two `byte_stb` pulses are never less than 10 cycles apart. If a comma starts r bits (0<r<10) after the current character boundary, the strobe interval that contains the comma is stretched to 10+r cycles.
- R6: A comma that starts exactly on the current character boundary leaves the strobe timing unchanged: every interval stays 10 cycles.
- R7: `comma_flag` is never high in a cycle where `byte_stb` is low.
- R8: In the cycle after `los` is sampled high, `data_out` is `10'h3FF`, and it stays `10'h3FF` while `los` stays high. While `los` is high, no comma is detected: there is no flag and no realignment.
- R9: After a realignment, the characters that follow the comma are delivered every 10 cycles on the new boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Retimed serial data bit |
| align_en | input | 1 | Enables comma hunting and realignment |
| los | input | 1 | Loss of signal; forces all-ones output |
| data_out | output | 10 | Parallel character, bit 0 received first |
| byte_stb | output | 1 | One-cycle byte-clock enable marking a new character |
| comma_flag | output | 1 | One-cycle flag marking the character holding a comma |

## Verification
The spacing and flag properties assume that commas never arrive in consecutive characters and that the stream contains no accidental comma prefix between real ones. Under that assumption, each strobe interval is either 10 cycles or a single stretch below 20. The stimulus keeps to this assumption by building filler characters with bits 4 and 9 forced to zero, which rules out any run of five ones across every concatenation. Pad bits around each inserted comma are chosen so that the prefix can match at only one position. Comma positions are placed deliberately: aligned, offset by three bits with alignment enabled, offset with alignment disabled, and inside a loss-of-signal window.

// File: rtl/dsr_pkg.sv
// Package: shared defaults for the comma-aligned deserializer.
// Assumes: bit 0 of every pattern/word is the first bit received.
package dsr_pkg;
    localparam int unsigned CHAR_W_DEF  = 10;
    localparam int unsigned PFX_W_DEF   = 7;
    // Arrival order 0,0,1,1,1,1,1 -> vector with bit 0 first
    localparam logic [PFX_W_DEF-1:0] PFX_PAT_DEF = 7'b1111100;
endpackage

// File: rtl/dsr_window.sv
// Module: dsr_window
// Sliding window of the most recent DEPTH serial bits. The newest bit enters
// at the top and the oldest sits at bit 0. The next-state window is exported
// so that decisions and captures see the bit arriving at this edge.
// Assumes: one valid bit per clock.
module dsr_window #(
    parameter int unsigned DEPTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic [DEPTH-1:0] win_next
);
    logic [DEPTH-1:0] win_q;

    // next window: shift toward bit 0, new bit at the top
    assign win_next = {ser_in, win_q[DEPTH-1:1]};

    // hold the window
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_next;
    end
endmodule

// File: rtl/dsr_comma_det.sv
// Module: dsr_comma_det
// Compares the look-ahead slice of the window with the comma prefix and
// raises hit when it matches, hunting is enabled and the line is alive.
// Assumes: look[0] is the oldest bit of the slice.
module dsr_comma_det #(
    parameter int unsigned       PFX_W   = 7,
    parameter logic [PFX_W-1:0]  PFX_PAT = 7'b1111100
) (
    input  logic [PFX_W-1:0] look,
    input  logic             align_en,
    input  logic             los,
    output logic             hit
);
    logic [PFX_W-1:0] bit_eq;

    // per-bit equality against the prefix
    for (genvar g = 0; g < PFX_W; g++) begin : g_cmp
        assign bit_eq[g] = (look[g] == PFX_PAT[g]);
    end

    // qualified match
    assign hit = align_en & ~los & (&bit_eq);
endmodule

// File: rtl/dsr_framer.sv
// Module: dsr_framer
// Bit counter that marks character ends. A comma hit restarts the count, so
// the next end falls exactly one character after the hit. Any pending end is
// cancelled, which only ever lengthens the running period. Also carries the
// comma marker to the strobe of the word that holds the comma.
// Assumes: CHAR_W >= PFX_W; hit is already qualified.
module dsr_framer #(
    parameter int unsigned CHAR_W = 10,
    parameter int unsigned PFX_W  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic los,
    output logic word_end,
    output logic stb_q,
    output logic flag_q
);
    localparam int unsigned CW      = $clog2(CHAR_W);
    localparam logic [CW-1:0] LAST  = CW'(CHAR_W - 1);
    // reset phase chosen so the first full word starts at the first bit
    localparam logic [CW-1:0] CNT_RST = CW'(CHAR_W - PFX_W);

    logic [CW-1:0] cnt;
    logic          pend;

    assign word_end = (cnt == LAST);

    // bit position within the current character
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= CNT_RST;
        else if (hit || word_end)  cnt <= '0;
        else                       cnt <= cnt + CW'(1);
    end

    // remember that the word now being assembled starts with a comma
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (hit)      pend <= 1'b1;
        else if (word_end) pend <= 1'b0;
    end

    // registered byte enable and comma flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            stb_q  <= word_end;
            flag_q <= word_end & pend & ~los;
        end
    end
endmodule

// File: rtl/comma_deser.sv
// Module: comma_deser (top)
// Serial-to-parallel converter with comma byte synchronisation. The window
// holds one character plus a comma-prefix look-ahead. The detector finds the
// prefix in the look-ahead, and the framer schedules the capture of the
// lower CHAR_W bits.
// Assumes: ser_in is retimed to clk; commas never in consecutive characters.
module comma_deser
    import dsr_pkg::*;
#(
    parameter int unsigned            CHAR_W  = CHAR_W_DEF,
    parameter int unsigned            PFX_W   = PFX_W_DEF,
    parameter logic [PFX_W_DEF-1:0]   PFX_PAT = PFX_PAT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              align_en,
    input  logic              los,
    output logic [CHAR_W-1:0] data_out,
    output logic              byte_stb,
    output logic              comma_flag
);
    localparam int unsigned DEPTH = CHAR_W + PFX_W;

    logic [DEPTH-1:0] win_next;
    logic             hit;
    logic             word_end;

    dsr_window #(.DEPTH(DEPTH)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .win_next (win_next)
    );

    dsr_comma_det #(.PFX_W(PFX_W), .PFX_PAT(PFX_PAT[PFX_W-1:0])) u_det (
        .look     (win_next[CHAR_W +: PFX_W]),
        .align_en (align_en),
        .los      (los),
        .hit      (hit)
    );

    dsr_framer #(.CHAR_W(CHAR_W), .PFX_W(PFX_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .los      (los),
        .word_end (word_end),
        .stb_q    (byte_stb),
        .flag_q   (comma_flag)
    );

    // parallel output: all ones on loss of signal, else capture at word end
    always_ff @(posedge clk) begin
        if (!rst_n)        data_out <= '0;
        else if (los)      data_out <= '1;
        else if (word_end) data_out <= win_next[CHAR_W-1:0];
    end
endmodule

// File: rtl/dsr_checker.sv
// Module: dsr_checker
// Temporal properties of comma_deser observed at its ports. A cycle counter
// measures strobe spacing without deep $past windows.
// Assumes: bound to every comma_deser instance.
module dsr_checker #(
    parameter int unsigned           CHAR_W  = 10,
    parameter int unsigned           PFX_W   = 7,
    parameter logic [PFX_W-1:0]      PFX_PAT = 7'b1111100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              los,
    input logic              byte_stb,
    input logic              comma_flag,
    input logic [CHAR_W-1:0] data_out
);
    localparam logic [7:0] MIN_GAP = 8'(CHAR_W);

    logic [7:0] gap;
    logic       started;

    // cycles since the previous strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= 8'd0;
            started <= 1'b0;
        end else begin
            gap <= byte_stb ? 8'd1 : ((gap == 8'hFF) ? gap : gap + 8'd1);
            if (byte_stb) started <= 1'b1;
        end
    end

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && started) |-> (gap >= MIN_GAP)); // R5

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb); // R2

    AST_FLAG_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> byte_stb); // R7

    AST_FLAG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> (data_out[PFX_W-1:0] == PFX_PAT)); // R3

    AST_LOS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(los) && $past(rst_n)) |-> (data_out == '1)); // R8
endmodule

bind comma_deser dsr_checker #(
    .CHAR_W  (CHAR_W),
    .PFX_W   (PFX_W),
    .PFX_PAT (PFX_PAT[PFX_W-1:0])
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .los        (los),
    .byte_stb   (byte_stb),
    .comma_flag (comma_flag),
    .data_out   (data_out)
);

// File: tb/sim_comma_deser.sv
// Bench for comma_deser: a behavioural model kept as a bit queue and integer
// edge numbers, compared on every clock, plus phase checks on strobe spacing.
module sim_comma_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       align_en = 1'b0;
    logic       los = 1'b0;
    logic [9:0] data_out;
    logic       byte_stb;
    logic       comma_flag;

    localparam logic [9:0] COMMA = 10'b0101111100; // arrival 0011111010

    always #10 clk = ~clk;

    comma_deser u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .align_en(align_en),
        .los(los), .data_out(data_out), .byte_stb(byte_stb),
        .comma_flag(comma_flag)
    );

    int checks = 0;
    int errors = 0;
    int bits[$];
    int n_edge = 0;
    int next_stb = 6;
    bit pend = 1'b0;
    logic [9:0] exp_data = '0;
    bit exp_stb = 1'b0;
    bit exp_flag = 1'b0;
    int ph_flags, ph_min, ph_max, ph_last, gap_ctr = 0;
    bit gap_valid = 1'b0;
    logic [9:0] flag_word = '0;

    function automatic int bitat(int i);
        return (i < 0) ? 0 : bits[i];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic ph_start();
        ph_flags = 0; ph_min = 1000; ph_max = 0; ph_last = 0;
    endtask

    task automatic send_bit(bit b);
        bit s_now, det;
        int n;
        ser_in = b;
        bits.push_back(int'(b));
        @(posedge clk); #1;
        n = n_edge;
        s_now = (n == next_stb);
        det = align_en && !los && bitat(n-6) == 0 && bitat(n-5) == 0 &&
              bitat(n-4) == 1 && bitat(n-3) == 1 && bitat(n-2) == 1 &&
              bitat(n-1) == 1 && bitat(n) == 1;
        exp_stb  = s_now;
        exp_flag = s_now && pend && !los;
        if (los) exp_data = '1;
        else if (s_now)
            for (int i = 0; i < 10; i++) exp_data[i] = (bitat(n - 16 + i) != 0);
        if (det) pend = 1'b1; else if (s_now) pend = 1'b0;
        if (det || s_now) next_stb = n + 10;
        n_edge++;
        @(negedge clk);
        chk(data_out === exp_data, los ? "R8" : "R2", "data_out", int'(data_out), int'(exp_data));
        chk(byte_stb === exp_stb, "R5", "byte_stb", int'(byte_stb), int'(exp_stb));
        chk(comma_flag === exp_flag, "R3", "comma_flag", int'(comma_flag), int'(exp_flag));
        chk(!(comma_flag && !byte_stb), "R7", "flag without strobe", int'(comma_flag), 0);
        gap_ctr++;
        if (byte_stb) begin
            if (gap_valid) begin
                if (gap_ctr < ph_min) ph_min = gap_ctr;
                if (gap_ctr > ph_max) ph_max = gap_ctr;
                ph_last = gap_ctr;
            end
            gap_valid = 1'b1;
            gap_ctr = 0;
        end
        if (comma_flag) begin
            ph_flags++;
            flag_word = data_out;
        end
    endtask

    task automatic send_char(logic [9:0] c);
        for (int i = 0; i < 10; i++) send_bit(c[i]);
    endtask

    function automatic logic [9:0] filler(int i);
        logic [9:0] v;
        v = 10'(i * 37 + 5);
        return v & 10'b0111101111;
    endfunction

    task automatic send_fill(int cnt, int seed);
        for (int i = 0; i < cnt; i++) send_char(filler(seed + i));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(data_out === 10'h000, "R1", "reset data", int'(data_out), 0);
        chk(byte_stb === 1'b0, "R1", "reset strobe", int'(byte_stb), 0);
        chk(comma_flag === 1'b0, "R1", "reset flag", int'(comma_flag), 0);
        rst_n = 1'b1;

        // Phase A: hunting off, misaligned comma must be ignored (R4)
        ph_start();
        align_en = 1'b0;
        send_fill(6, 1);
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        send_char(COMMA);
        send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(1);
        send_fill(3, 20);
        chk(ph_flags == 0, "R4", "flags with hunting off", ph_flags, 0);
        chk(ph_min == 10 && ph_max == 10, "R4", "interval", ph_max, 10);

        // Phase B: comma three bits past the boundary -> stretch to 13 (R5, R3, R9)
        ph_start();
        align_en = 1'b1;
        send_fill(2, 30);
        send_bit(1); send_bit(0); send_bit(1);
        send_char(COMMA);
        send_fill(4, 40);
        chk(ph_max == 13, "R5", "stretched interval", ph_max, 13);
        chk(ph_min >= 10, "R5", "shortest interval", ph_min, 10);
        chk(ph_flags == 1, "R3", "flag count", ph_flags, 1);
        chk(flag_word == COMMA, "R3", "word with flag", int'(flag_word), int'(COMMA));
        chk(ph_last == 10, "R9", "interval after realign", ph_last, 10);

        // Phase C: comma on the current boundary -> no timing change (R6)
        ph_start();
        send_fill(2, 50);
        send_char(COMMA);
        send_fill(3, 60);
        chk(ph_min == 10 && ph_max == 10, "R6", "interval", ph_max, 10);
        chk(ph_flags == 1, "R6", "flag count", ph_flags, 1);
        chk(flag_word == COMMA, "R6", "word with flag", int'(flag_word), int'(COMMA));

        // Phase D: loss of signal, misaligned comma inside it (R8)
        ph_start();
        los = 1'b1;
        send_bit(1); send_bit(0);
        chk(data_out == 10'h3FF, "R8", "forced ones", int'(data_out), 10'h3FF);
        send_char(COMMA);
        send_bit(0); send_bit(1); send_bit(0); send_bit(1);
        send_bit(0); send_bit(1); send_bit(0); send_bit(1);
        chk(data_out == 10'h3FF, "R8", "still ones", int'(data_out), 10'h3FF);
        los = 1'b0;
        send_fill(3, 70);
        chk(ph_flags == 0, "R8", "flags under los", ph_flags, 0);
        chk(ph_min == 10 && ph_max == 10, "R8", "no realign under los", ph_max, 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule